// File: doc/BRIEF.md
# Batched Remote-Call Queue with Hint-Driven Prefetch

This block sits beside a vault's in-order core and collects incoming non-blocking remote-call messages so the core can run them in batches. A message may carry one optional memory address. When such a hinted message is accepted, the block requests a prefetch of that address, and the message only counts as ready once the matching completion comes back. A message with no hint is ready as soon as it is stored.

The block raises an interrupt in one of three cases: the number of ready messages exceeds a threshold, every slot is occupied, or a barrier is signalled. Each case decides which messages the core then receives. In batch mode the core receives only ready messages, so a call never stalls on its own data. In drain mode, entered on a full queue or a barrier, the core receives every stored message, ready or not. The number of prefetches in flight is capped. Hinted messages that arrive while the cap is reached wait and issue in arrival order. Prefetch completions are matched to messages by a tag that equals the slot index.

Top module: `mq_prefetch_queue`

## Requirements
- R1: A message is accepted (in_valid and in_ready) into the lowest-indexed slot that is free. A slot is free when it holds no message and has no prefetch still owed to it. in_ready is low exactly when no slot is free.
- R2: A hinted message accepted while fewer than MAX_PF prefetches are outstanding and no hinted message is waiting drives pf_req_valid in its acceptance cycle, with pf_req_addr equal to the hint and pf_req_tag equal to the slot index.
- R3: A message without a hint is ready from the cycle after acceptance and never causes a prefetch request.
- R4: A hinted message becomes ready in the cycle after pf_done_valid arrives with its slot index as pf_done_tag. Before then it is never handed out in batch mode.
- R5: When the block is collecting and the count of ready messages exceeds THRESH, it enters batch mode in the next cycle and irq rises.
- R6: In batch mode out_valid presents the lowest-indexed ready message. The block returns to collecting, with irq low, the cycle after it observes no ready message.
- R7: When all DEPTH slots hold messages, the block enters drain mode in the next cycle. Drain mode presents the lowest-indexed stored message whether ready or not, keeps irq high, and ends the cycle after the queue is observed empty.
- R8: A barrier pulse in a cycle in which at least one message is stored puts the block into drain mode in the next cycle. A barrier pulse in a cycle with no stored message has no effect.
- R9: At most MAX_PF prefetches are outstanding. Waiting hinted messages issue one per cycle in arrival order as room appears. A waiting message removed before it issues never issues.
- R10: After reset, irq, out_valid and pf_req_valid are low and in_ready is high.
- R11: While collecting, out_valid and irq stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming message present |
| in_ready | output | 1 | A slot is free to accept the message |
| in_has_hint | input | 1 | Incoming message carries a prefetch address |
| in_hint_addr | input | ADDR_W | Prefetch address of the incoming message |
| in_payload | input | PAYLOAD_W | Message body (function pointer and arguments) |
| pf_req_valid | output | 1 | Prefetch request issued this cycle |
| pf_req_addr | output | ADDR_W | Address to prefetch |
| pf_req_tag | output | IDX_W | Slot index the request belongs to |
| pf_done_valid | input | 1 | A prefetch has been serviced |
| pf_done_tag | input | IDX_W | Slot index of the serviced prefetch |
| barrier | input | 1 | Single-cycle barrier pulse |
| irq | output | 1 | Batch interrupt to the core (batch or drain mode) |
| out_valid | output | 1 | Message offered to the core |
| out_ready | input | 1 | Core takes the offered message |
| out_payload | output | PAYLOAD_W | Body of the offered message |

## Verification
The bench builds the queue with DEPTH 8, THRESH 3 and MAX_PF 2. At these values a full queue, a saturated prefetch limit with several hinted messages waiting, and a drain that removes waiting messages before their prefetch issues all occur within a few dozen messages. The same values let long random runs move through collecting, batch and drain many times. A slot-level reference model in the bench predicts in_ready, every prefetch request, the offered payload and irq in every cycle.

// File: rtl/mq_pkg.sv
package mq_pkg;
   typedef enum logic [1:0] {
      MQ_COLLECT = 2'd0,
      MQ_BATCH   = 2'd1,
      MQ_DRAIN   = 2'd2
   } mq_mode_e;
endpackage

// File: rtl/mq_slot.sv
module mq_slot #(
   parameter int PAYLOAD_W = 64,
   parameter int ADDR_W    = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 alloc_i,
   input  logic                 hint_i,
   input  logic [PAYLOAD_W-1:0] payload_i,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic                 done_i,
   input  logic                 release_i,
   input  logic                 drop_i,
   output logic                 valid_o,
   output logic                 rdy_o,
   output logic                 busy_o,
   output logic [PAYLOAD_W-1:0] payload_o,
   output logic [ADDR_W-1:0]    addr_o
);
   logic valid_q, rdy_q, busy_q;
   logic [PAYLOAD_W-1:0] pay_q;
   logic [ADDR_W-1:0]    addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         rdy_q   <= 1'b0;
         busy_q  <= 1'b0;
      end else if (alloc_i) begin
         valid_q <= 1'b1;
         rdy_q   <= !hint_i;
         busy_q  <= hint_i;
      end else begin
         if (release_i) begin
            valid_q <= 1'b0;
            rdy_q   <= 1'b0;
         end else if (done_i && valid_q) begin
            rdy_q   <= 1'b1;
         end
         if (done_i || drop_i) busy_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (alloc_i) begin
         pay_q  <= payload_i;
         addr_q <= addr_i;
      end
   end

   assign valid_o   = valid_q;
   assign rdy_o     = rdy_q;
   assign busy_o    = busy_q;
   assign payload_o = pay_q;
   assign addr_o    = addr_q;
endmodule

// File: rtl/mq_pf_issue.sv
module mq_pf_issue #(
   parameter int DEPTH  = 32,
   parameter int MAX_PF = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       new_hint_i,
   input  logic [$clog2(DEPTH)-1:0]   new_tag_i,
   input  logic [DEPTH-1:0]           slot_valid_i,
   input  logic                       done_i,
   output logic                       issue_o,
   output logic                       from_fifo_o,
   output logic [$clog2(DEPTH)-1:0]   issue_tag_o,
   output logic                       drop_o,
   output logic [$clog2(DEPTH)-1:0]   drop_tag_o,
   output logic [$clog2(MAX_PF+1)-1:0] outstanding_o
);
   localparam int IDX_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int PFC_W = $clog2(MAX_PF + 1);

   logic [IDX_W-1:0] wait_mem [DEPTH];
   logic [IDX_W-1:0] rd_q, wr_q;
   logic [CNT_W-1:0] cnt_q;
   logic [PFC_W-1:0] outst_q;
   logic [IDX_W-1:0] head;
   logic room, push, pop;

   assign head = wait_mem[rd_q];
   assign room = outst_q < PFC_W'(MAX_PF);

   always_comb begin
      issue_o     = 1'b0;
      from_fifo_o = 1'b0;
      issue_tag_o = new_tag_i;
      drop_o      = 1'b0;
      push        = 1'b0;
      pop         = 1'b0;
      if (cnt_q != '0) begin
         if (!slot_valid_i[head]) begin
            pop    = 1'b1;
            drop_o = 1'b1;
         end else if (room) begin
            pop         = 1'b1;
            issue_o     = 1'b1;
            from_fifo_o = 1'b1;
            issue_tag_o = head;
         end
         push = new_hint_i;
      end else if (new_hint_i) begin
         if (room) issue_o = 1'b1;
         else      push    = 1'b1;
      end
   end

   assign drop_tag_o    = head;
   assign outstanding_o = outst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q    <= '0;
         wr_q    <= '0;
         cnt_q   <= '0;
         outst_q <= '0;
      end else begin
         if (push) wr_q <= wr_q + 1'b1;
         if (pop)  rd_q <= rd_q + 1'b1;
         cnt_q   <= cnt_q + CNT_W'(push) - CNT_W'(pop);
         outst_q <= outst_q + PFC_W'(issue_o) - PFC_W'(done_i);
      end
   end

   always_ff @(posedge clk) begin
      if (push) wait_mem[wr_q] <= new_tag_i;
   end
endmodule

// File: rtl/mq_batch_ctrl.sv
module mq_batch_ctrl
   import mq_pkg::*;
#(
   parameter int DEPTH  = 32,
   parameter int THRESH = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [$clog2(DEPTH+1)-1:0] occ_cnt_i,
   input  logic [$clog2(DEPTH+1)-1:0] rdy_cnt_i,
   input  logic                       barrier_i,
   output mq_mode_e                   mode_o
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   mq_mode_e mode_q, mode_d;
   logic any_msg, full, flush, enough;

   assign any_msg = occ_cnt_i != '0;
   assign full    = occ_cnt_i == CNT_W'(DEPTH);
   assign flush   = (barrier_i && any_msg) || full;
   assign enough  = rdy_cnt_i > CNT_W'(THRESH);

   always_comb begin
      mode_d = mode_q;
      unique case (mode_q)
         MQ_COLLECT: if (flush) mode_d = MQ_DRAIN;
                     else if (enough) mode_d = MQ_BATCH;
         MQ_BATCH:   if (flush) mode_d = MQ_DRAIN;
                     else if (rdy_cnt_i == '0) mode_d = MQ_COLLECT;
         MQ_DRAIN:   if (!any_msg) mode_d = MQ_COLLECT;
         default:    mode_d = MQ_COLLECT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MQ_COLLECT;
      else        mode_q <= mode_d;
   end

   assign mode_o = mode_q;
endmodule

// File: rtl/mq_prefetch_queue.sv
module mq_prefetch_queue
   import mq_pkg::*;
#(
   parameter int DEPTH     = 32,
   parameter int THRESH    = 16,
   parameter int MAX_PF    = 16,
   parameter int PAYLOAD_W = 64,
   parameter int ADDR_W    = 32,
   localparam int IDX_W    = $clog2(DEPTH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic                 in_has_hint,
   input  logic [ADDR_W-1:0]    in_hint_addr,
   input  logic [PAYLOAD_W-1:0] in_payload,
   output logic                 pf_req_valid,
   output logic [ADDR_W-1:0]    pf_req_addr,
   output logic [IDX_W-1:0]     pf_req_tag,
   input  logic                 pf_done_valid,
   input  logic [IDX_W-1:0]     pf_done_tag,
   input  logic                 barrier,
   output logic                 irq,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [PAYLOAD_W-1:0] out_payload
);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int PFC_W = $clog2(MAX_PF + 1);

   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (THRESH < 0 || THRESH >= DEPTH) begin : g_bad_thresh
      $error("THRESH must lie in 0..DEPTH-1");
   end
   if (MAX_PF < 1 || MAX_PF > DEPTH) begin : g_bad_pf
      $error("MAX_PF must lie in 1..DEPTH");
   end

   logic [DEPTH-1:0] slot_valid, slot_rdy, slot_busy, slot_free, slot_elig;
   logic [DEPTH-1:0] alloc_v, release_v, done_v, drop_v;
   logic [PAYLOAD_W-1:0] slot_pay  [DEPTH];
   logic [ADDR_W-1:0]    slot_addr [DEPTH];

   logic [IDX_W-1:0] enq_idx, out_idx, issue_tag, drop_tag;
   logic have_free, have_out, in_fire, out_fire;
   logic issue, from_fifo, drop;
   logic [CNT_W-1:0] occ_cnt, rdy_cnt;
   logic [PFC_W-1:0] outstanding;
   mq_mode_e mode_q;

   assign slot_free = ~slot_valid & ~slot_busy;
   assign occ_cnt   = CNT_W'($countones(slot_valid));
   assign rdy_cnt   = CNT_W'($countones(slot_valid & slot_rdy));

   always_comb begin
      slot_elig = '0;
      if (mode_q == MQ_DRAIN)      slot_elig = slot_valid;
      else if (mode_q == MQ_BATCH) slot_elig = slot_valid & slot_rdy;
   end

   always_comb begin
      enq_idx   = '0;
      have_free = 1'b0;
      out_idx   = '0;
      have_out  = 1'b0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (slot_free[i]) begin
            enq_idx   = IDX_W'(i);
            have_free = 1'b1;
         end
         if (slot_elig[i]) begin
            out_idx  = IDX_W'(i);
            have_out = 1'b1;
         end
      end
   end

   assign in_ready    = have_free;
   assign in_fire     = in_valid && have_free;
   assign out_valid   = have_out;
   assign out_fire    = have_out && out_ready;
   assign out_payload = slot_pay[out_idx];
   assign irq         = mode_q != MQ_COLLECT;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      assign alloc_v[g]   = in_fire && (enq_idx == IDX_W'(g));
      assign release_v[g] = out_fire && (out_idx == IDX_W'(g));
      assign done_v[g]    = pf_done_valid && (pf_done_tag == IDX_W'(g));
      assign drop_v[g]    = drop && (drop_tag == IDX_W'(g));

      mq_slot #(
         .PAYLOAD_W (PAYLOAD_W),
         .ADDR_W    (ADDR_W)
      ) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .alloc_i   (alloc_v[g]),
         .hint_i    (in_has_hint),
         .payload_i (in_payload),
         .addr_i    (in_hint_addr),
         .done_i    (done_v[g]),
         .release_i (release_v[g]),
         .drop_i    (drop_v[g]),
         .valid_o   (slot_valid[g]),
         .rdy_o     (slot_rdy[g]),
         .busy_o    (slot_busy[g]),
         .payload_o (slot_pay[g]),
         .addr_o    (slot_addr[g])
      );
   end

   mq_pf_issue #(
      .DEPTH  (DEPTH),
      .MAX_PF (MAX_PF)
   ) u_issue (
      .clk           (clk),
      .rst_n         (rst_n),
      .new_hint_i    (in_fire && in_has_hint),
      .new_tag_i     (enq_idx),
      .slot_valid_i  (slot_valid),
      .done_i        (pf_done_valid),
      .issue_o       (issue),
      .from_fifo_o   (from_fifo),
      .issue_tag_o   (issue_tag),
      .drop_o        (drop),
      .drop_tag_o    (drop_tag),
      .outstanding_o (outstanding)
   );

   assign pf_req_valid = issue;
   assign pf_req_tag   = issue_tag;
   assign pf_req_addr  = from_fifo ? slot_addr[issue_tag] : in_hint_addr;

   mq_batch_ctrl #(
      .DEPTH  (DEPTH),
      .THRESH (THRESH)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .occ_cnt_i (occ_cnt),
      .rdy_cnt_i (rdy_cnt),
      .barrier_i (barrier),
      .mode_o    (mode_q)
   );
endmodule

// File: rtl/mq_prefetch_queue_chk.sv
module mq_prefetch_queue_chk #(
   parameter int DEPTH  = 32,
   parameter int THRESH = 16,
   parameter int MAX_PF = 16,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int PFC_W = $clog2(MAX_PF + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             in_has_hint,
   input logic             pf_req_valid,
   input logic             out_valid,
   input logic             irq,
   input logic             barrier,
   input logic [1:0]       mode,
   input logic [CNT_W-1:0] occ_cnt,
   input logic [CNT_W-1:0] rdy_cnt,
   input logic [PFC_W-1:0] outstanding,
   input logic [DEPTH-1:0] slot_rdy,
   input logic [IDX_W-1:0] enq_idx,
   input logic [IDX_W-1:0] out_idx
);
   localparam logic [1:0] M_BATCH = 2'd1;
   localparam logic [1:0] M_DRAIN = 2'd2;

   assert_backpressure_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (occ_cnt == CNT_W'(DEPTH)) |-> !in_ready);

   assert_nohint_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !in_has_hint) |=> slot_rdy[$past(enq_idx)]);

   assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(barrier || occ_cnt == CNT_W'(DEPTH) || rdy_cnt > CNT_W'(THRESH)));

   assert_batch_ready_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_BATCH && out_valid) |-> slot_rdy[out_idx]);

   assert_out_under_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> irq);

   assert_drain_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_DRAIN && occ_cnt != '0) |=> irq);

   assert_pf_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      outstanding <= PFC_W'(MAX_PF));

   assert_issue_room_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pf_req_valid |-> outstanding < PFC_W'(MAX_PF));
endmodule

bind mq_prefetch_queue mq_prefetch_queue_chk #(
   .DEPTH  (DEPTH),
   .THRESH (THRESH),
   .MAX_PF (MAX_PF)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_ready     (in_ready),
   .in_has_hint  (in_has_hint),
   .pf_req_valid (pf_req_valid),
   .out_valid    (out_valid),
   .irq          (irq),
   .barrier      (barrier),
   .mode         (mode_q),
   .occ_cnt      (occ_cnt),
   .rdy_cnt      (rdy_cnt),
   .outstanding  (outstanding),
   .slot_rdy     (slot_rdy),
   .enq_idx      (enq_idx),
   .out_idx      (out_idx)
);

// File: tb/mq_prefetch_queue_tb.sv
module mq_prefetch_queue_tb_top;
   localparam int D  = 8;
   localparam int TH = 3;
   localparam int MP = 2;
   localparam int PW = 16;
   localparam int AW = 12;
   localparam int IW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_has_hint = 1'b0;
   logic [AW-1:0] in_hint_addr = '0;
   logic [PW-1:0] in_payload = '0;
   logic pf_done_valid = 1'b0;
   logic [IW-1:0] pf_done_tag = '0;
   logic barrier = 1'b0, out_ready = 1'b0;
   logic in_ready, pf_req_valid, irq, out_valid;
   logic [AW-1:0] pf_req_addr;
   logic [IW-1:0] pf_req_tag;
   logic [PW-1:0] out_payload;

   always #5 clk = ~clk;

   mq_prefetch_queue #(
      .DEPTH (D), .THRESH (TH), .MAX_PF (MP), .PAYLOAD_W (PW), .ADDR_W (AW)
   ) dut_i (
      .clk (clk), .rst_n (rst_n),
      .in_valid (in_valid), .in_ready (in_ready), .in_has_hint (in_has_hint),
      .in_hint_addr (in_hint_addr), .in_payload (in_payload),
      .pf_req_valid (pf_req_valid), .pf_req_addr (pf_req_addr), .pf_req_tag (pf_req_tag),
      .pf_done_valid (pf_done_valid), .pf_done_tag (pf_done_tag),
      .barrier (barrier), .irq (irq),
      .out_valid (out_valid), .out_ready (out_ready), .out_payload (out_payload)
   );

   int checks = 0, errors = 0;
   bit finished = 0;

   // reference model state
   bit mv [D], mr [D], mb [D], infl [D];
   logic [PW-1:0] mpay [D];
   logic [AW-1:0] maddr [D];
   int mq [D];
   int mq_rd = 0, mq_wr = 0, mq_cnt = 0, m_out = 0, m_mode = 0;
   int pay_ctr = 1;
   string irq_tag = "R5";

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic drive(bit v, bit h, int pr_out, int pr_done, bit bar);
      int cand [$];
      in_valid     = v;
      in_has_hint  = h;
      in_payload   = PW'(pay_ctr);
      in_hint_addr = AW'($urandom);
      out_ready    = ($urandom % 100) < pr_out;
      barrier      = bar;
      pf_done_valid = 1'b0;
      for (int i = 0; i < D; i++) if (infl[i]) cand.push_back(i);
      if (cand.size() > 0 && ($urandom % 100) < pr_done) begin
         pf_done_valid = 1'b1;
         pf_done_tag   = IW'(cand[$urandom % cand.size()]);
      end
   endtask

   task automatic step();
      int eidx, oidx, head, occ, rc, nmode, itag;
      bit fire, room, iss, push, pop, drop;
      logic [AW-1:0] iaddr;
      string tg;
      #2;
      eidx = -1;
      for (int i = D - 1; i >= 0; i--) if (!mv[i] && !mb[i]) eidx = i;
      fire = in_valid && (eidx >= 0);
      chk(in_ready === (eidx >= 0), "R1", "in_ready", in_ready, eidx >= 0);
      room = m_out < MP;
      iss = 0; push = 0; pop = 0; drop = 0; itag = 0; iaddr = '0;
      head = mq[mq_rd];
      if (mq_cnt > 0) begin
         if (!mv[head]) begin pop = 1; drop = 1; end
         else if (room) begin pop = 1; iss = 1; itag = head; iaddr = maddr[head]; end
         if (fire && in_has_hint) push = 1;
      end else if (fire && in_has_hint) begin
         if (room) begin iss = 1; itag = eidx; iaddr = in_hint_addr; end
         else push = 1;
      end
      tg = (fire && !in_has_hint && mq_cnt == 0) ? "R3" : "R9";
      chk(pf_req_valid === iss, tg, "pf_req_valid", pf_req_valid, iss);
      if (iss && pf_req_valid === 1'b1) begin
         chk(pf_req_tag === IW'(itag), "R2", "pf_req_tag", pf_req_tag, itag);
         chk(pf_req_addr === iaddr, "R2", "pf_req_addr", pf_req_addr, iaddr);
      end
      oidx = -1;
      for (int i = D - 1; i >= 0; i--)
         if (mv[i] && (m_mode == 2 || (m_mode == 1 && mr[i]))) oidx = i;
      tg = (m_mode == 0) ? "R11" : (m_mode == 1) ? "R6" : "R7";
      chk(out_valid === (oidx >= 0), tg, "out_valid", out_valid, oidx >= 0);
      if (oidx >= 0 && out_valid === 1'b1)
         chk(out_payload === mpay[oidx], (m_mode == 1) ? "R4" : "R7", "out_payload",
             out_payload, mpay[oidx]);
      chk(irq === (m_mode != 0), (m_mode == 0) ? "R11" : irq_tag, "irq", irq, m_mode != 0);

      occ = 0; rc = 0;
      for (int i = 0; i < D; i++) begin
         occ += mv[i];
         rc  += (mv[i] && mr[i]);
      end
      nmode = m_mode;
      if (m_mode == 0 || m_mode == 1) begin
         if (barrier && occ > 0) begin nmode = 2; irq_tag = "R8"; end
         else if (occ == D) begin nmode = 2; irq_tag = "R7"; end
         else if (m_mode == 0 && rc > TH) begin nmode = 1; irq_tag = "R5"; end
         else if (m_mode == 1 && rc == 0) nmode = 0;
      end else if (occ == 0) nmode = 0;

      @(posedge clk);
      for (int i = 0; i < D; i++) begin
         bit al, rl, dn, dr;
         al = fire && i == eidx;
         rl = (oidx >= 0) && out_ready && i == oidx;
         dn = pf_done_valid && pf_done_tag == IW'(i);
         dr = drop && i == head;
         if (al) begin
            mv[i] = 1; mr[i] = !in_has_hint; mb[i] = in_has_hint;
            mpay[i] = in_payload; maddr[i] = in_hint_addr;
         end else begin
            if (rl) begin mv[i] = 0; mr[i] = 0; end
            else if (dn && mv[i]) mr[i] = 1;
            if (dn || dr) mb[i] = 0;
         end
      end
      if (pf_done_valid) infl[pf_done_tag] = 0;
      if (iss) infl[itag] = 1;
      if (push) begin mq[mq_wr] = eidx; mq_wr = (mq_wr + 1) % D; end
      if (pop) mq_rd = (mq_rd + 1) % D;
      mq_cnt += int'(push) - int'(pop);
      m_out  += int'(iss) - int'(pf_done_valid);
      m_mode = nmode;
      if (fire) pay_ctr++;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL R10 watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #2;
      // R10: state after reset
      chk(irq === 1'b0, "R10", "irq", irq, 0);
      chk(out_valid === 1'b0, "R10", "out_valid", out_valid, 0);
      chk(pf_req_valid === 1'b0, "R10", "pf_req_valid", pf_req_valid, 0);
      chk(in_ready === 1'b1, "R10", "in_ready", in_ready, 1);
      @(negedge clk);

      // R3/R5/R6: unhinted messages cross the threshold, then the batch drains
      for (int k = 0; k < 4; k++) begin drive(1, 0, 0, 0, 0); step(); end
      for (int k = 0; k < 8; k++) begin drive(0, 0, 100, 0, 0); step(); end

      // R2/R9: three hinted messages against a limit of two
      for (int k = 0; k < 3; k++) begin drive(1, 1, 100, 0, 0); step(); end
      for (int k = 0; k < 3; k++) begin drive(0, 0, 100, 0, 0); step(); end
      for (int k = 0; k < 12; k++) begin drive(0, 0, 100, 100, 0); step(); end

      // R7/R9: fill with hinted messages, drain before their prefetches issue
      for (int k = 0; k < 8; k++) begin drive(1, 1, 0, 0, 0); step(); end
      for (int k = 0; k < 10; k++) begin drive(0, 0, 100, 0, 0); step(); end
      for (int k = 0; k < 12; k++) begin drive(0, 0, 100, 100, 0); step(); end

      // R8: barrier on an empty queue is ignored, then barrier with two stored
      drive(0, 0, 100, 0, 1); step();
      drive(0, 0, 100, 0, 0); step();
      for (int k = 0; k < 2; k++) begin drive(1, 1, 0, 0, 0); step(); end
      drive(0, 0, 0, 0, 1); step();
      for (int k = 0; k < 6; k++) begin drive(0, 0, 100, 0, 0); step(); end
      for (int k = 0; k < 8; k++) begin drive(0, 0, 100, 100, 0); step(); end

      // mixed random traffic
      for (int k = 0; k < 4000; k++) begin
         drive(($urandom % 100) < 55, $urandom % 2, 60, 40, ($urandom % 100) < 2);
         step();
      end
      for (int k = 0; k < 40; k++) begin drive(0, 0, 100, 100, k == 0); step(); end

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule